// File: doc/BRIEF.md
# Bad-Block-Skipping Boot Image Loader

This sequencer fetches a boot image from NAND flash one page at a time. It is given a byte offset in flash, an image length in bytes and a destination base address. It then issues page-read requests to an external page reader and writes nothing itself. Each request names a flash page and the destination address for that page's data. The reader moves the data, runs the ECC decoder and answers with one status beat per ECC sector. The first beat of a page also carries the first two spare-area bytes.

The loader walks the flash one erase block at a time. A block is dropped when one of its readable pages carries a bad-block marker, or when none of its pages can be read. When a block is dropped, the destination does not advance and the next block is tried. A read failure inside a block that carries no marker ends the load with an error. A successful load ends with a done pulse and the largest corrected-bit count seen.

Request and response transfers use valid/ready. A request is held, unchanged, until the reader accepts it. The loader raises its sector-ready line only while it waits for the beats of the page it has just requested. The reader may therefore stall either channel for any number of cycles. The one exception is the sector channel, which may stay idle only up to the timeout.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset, busy, done, error, rd_abandon and req_valid are low.
- R2: A start pulse is accepted only while busy is low. The first request then names page offset/PAGE_BYTES, with the destination equal to the base address. A start pulse while busy has no effect on the running load.
- R3: A zero image size completes with a done pulse two cycles after start, and no page request is issued.
- R4: The page count is size/PAGE_BYTES rounded up, and the block count is size/(PAGE_BYTES*PAGES_PER_BLOCK) rounded up. A block reads the lesser of PAGES_PER_BLOCK and the pages still owed, at consecutive page numbers. Page i of a block goes to the block's destination plus i*PAGE_BYTES.
- R5: In a sector status byte, bit 6 set marks the sector as failed, and any failed sector makes the page unreadable. When bit 3 is set, the sector's corrected count is bits 5:4 plus one; otherwise it is zero. max_flips, valid with done, is the largest count over the sectors of every readable page read during the load.
- R6: A readable page is marker-flagged when either spare byte of its first beat is not 0xFF. Spare bytes on later beats are ignored. The block is then bad, and none of its remaining pages is requested.
- R7: A block in which no page was readable is bad.
- R8: After a bad block, the destination and the owed byte, page and block counts are unchanged. After a good block, the destination advances by the lesser of the bytes owed and one block's bytes. In both cases the next block starts PAGES_PER_BLOCK pages after the previous block's first page.
- R9: An unreadable page in a block with no marker ends the load with an error pulse, and no further request is issued.
- R10: If no sector beat arrives within TIMEOUT_CYC cycles, the page is unreadable. rd_abandon pulses once, and the loader accepts no further beats for that page.
- R11: req_valid, req_page and req_dst stay stable until req_ready. sec_ready is never high while req_valid is high. Exactly SECTORS beats are accepted for each page that does not time out.
- R12: done and error are single-cycle pulses, never high together. busy is low in the cycle either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a load (honoured when idle) |
| img_offset | input | ADDR_W | Byte offset of the image in flash |
| img_size | input | SIZE_W | Image length in bytes |
| dst_base | input | ADDR_W | Destination address of the first byte |
| req_valid | output | 1 | Page-read request valid |
| req_ready | input | 1 | Page reader accepts the request |
| req_page | output | ADDR_W-log2(PAGE_BYTES) | Flash page number to read |
| req_dst | output | ADDR_W | Destination address for the page |
| sec_valid | input | 1 | Sector status beat valid |
| sec_ready | output | 1 | Loader accepts a sector beat |
| sec_status | input | 8 | Decoder status for one sector |
| sec_spare0 | input | 8 | Spare byte 0 (first beat of a page) |
| sec_spare1 | input | 8 | Spare byte 1 (first beat of a page) |
| rd_abandon | output | 1 | Pulse: the current page timed out and is dropped |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Pulse: load finished successfully |
| error | output | 1 | Pulse: load aborted on a read error |
| max_flips | output | 3 | Largest corrected-bit count, valid with done |

## Verification
The bench builds the loader with 16-byte pages, 4-page blocks, 4 sectors per page, a 20-cycle timeout, 16-bit addresses and a 12-bit size. With these values an image of a few hundred bytes spans several blocks, and each scenario finishes within a few hundred cycles. The bench sweeps offsets that are not aligned to blocks, sizes that end in partial pages and partial blocks, and fault layouts drawn over a 256-page flash table. These layouts include marker pages, failed sectors, whole unreadable blocks, a failure followed by a marker, and pages that never answer. Even the timeout is cheap to reach with this build.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLOCK,
    ST_REQ,
    ST_COLLECT,
    ST_VERDICT
  } nbl_state_e;

  // Sector status field positions.
  localparam int STS_FAIL   = 6;
  localparam int STS_CORR   = 3;
  localparam int STS_CNT_LO = 4;

  localparam logic [7:0] SPARE_ERASED = 8'hFF;

  // Corrected-bit count carried by one sector status byte.
  function automatic logic [2:0] sector_flips(input logic [7:0] st);
    logic [2:0] n;
    n = {1'b0, st[STS_CNT_LO+1:STS_CNT_LO]} + 3'd1;
    return st[STS_CORR] ? n : 3'd0;
  endfunction

endpackage

// File: rtl/nbl_sector_merge.sv
// Folds the per-sector beats of one page into a page verdict, with timeout.
module nbl_sector_merge
  import nbl_pkg::*;
#(
  parameter int SECTORS     = 4,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       active,
  input  logic       sec_valid,
  input  logic [7:0] sec_status,
  input  logic [7:0] sec_spare0,
  input  logic [7:0] sec_spare1,
  output logic       sec_ready,
  output logic       pg_fin,
  output logic       pg_ok,
  output logic       pg_mark,
  output logic [2:0] pg_flips,
  output logic       pg_timeout
);

  localparam int BW = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [BW-1:0] beat_cnt;
  logic          fail_acc;
  logic          mark_acc;
  logic [2:0]    flip_acc;
  logic [TW-1:0] idle_cnt;

  logic       take;
  logic       last_beat;
  logic [2:0] cur_flips;
  logic       cur_mark;

  assign sec_ready  = active;
  assign take       = active && sec_valid;
  assign cur_flips  = sector_flips(sec_status);
  assign cur_mark   = (sec_spare0 != SPARE_ERASED) || (sec_spare1 != SPARE_ERASED);
  assign last_beat  = (beat_cnt == BW'(SECTORS - 1));
  assign pg_timeout = active && !sec_valid && (idle_cnt == TW'(TIMEOUT_CYC - 1));
  assign pg_fin     = (take && last_beat) || pg_timeout;
  assign pg_ok      = !pg_timeout && !fail_acc && !(take && sec_status[STS_FAIL]);
  assign pg_flips   = (take && (cur_flips > flip_acc)) ? cur_flips : flip_acc;
  assign pg_mark    = (take && (beat_cnt == '0)) ? cur_mark : mark_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      fail_acc <= 1'b0;
      mark_acc <= 1'b0;
      flip_acc <= '0;
      idle_cnt <= '0;
    end else if (arm) begin
      beat_cnt <= '0;
      fail_acc <= 1'b0;
      mark_acc <= 1'b0;
      flip_acc <= '0;
      idle_cnt <= '0;
    end else if (take) begin
      beat_cnt <= last_beat ? '0 : beat_cnt + BW'(1);
      fail_acc <= fail_acc | sec_status[STS_FAIL];
      flip_acc <= pg_flips;
      if (beat_cnt == '0) mark_acc <= cur_mark;
      idle_cnt <= '0;
    end else if (active) begin
      idle_cnt <= idle_cnt + TW'(1);
    end
  end

  // R10: the silence counter never passes the timeout window
  a_r10_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idle_cnt < TW'(TIMEOUT_CYC)));

endmodule

// File: rtl/nbl_block_tally.sv
// Per-block record of readable pages, failed pages and markers.
module nbl_block_tally (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic pg_fin,
  input  logic pg_ok,
  input  logic pg_mark,
  output logic any_good,
  output logic any_err,
  output logic marked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_good <= 1'b0;
      any_err  <= 1'b0;
      marked   <= 1'b0;
    end else if (clear) begin
      any_good <= 1'b0;
      any_err  <= 1'b0;
      marked   <= 1'b0;
    end else if (pg_fin) begin
      if (pg_ok) begin
        any_good <= 1'b1;
        if (pg_mark) marked <= 1'b1;
      end else begin
        any_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nbl_image_track.sv
// Remaining byte/page/block counts, block page pointer and destination.
module nbl_image_track #(
  parameter int ADDR_W          = 32,
  parameter int SIZE_W          = 24,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  localparam int PS     = $clog2(PAGE_BYTES),
  localparam int BS     = PS + $clog2(PAGES_PER_BLOCK),
  localparam int PAGE_W = ADDR_W - PS,
  localparam int CNT_W  = SIZE_W - PS + 1,
  localparam int PIDX_W = $clog2(PAGES_PER_BLOCK) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              step,
  input  logic              keep,
  output logic [PAGE_W-1:0] blk_page,
  output logic [ADDR_W-1:0] blk_dst,
  output logic              no_blocks,
  output logic [PIDX_W-1:0] blk_pages
);

  localparam int BLK_BYTES = PAGE_BYTES * PAGES_PER_BLOCK;

  logic [SIZE_W-1:0] bytes_left;
  logic [CNT_W-1:0]  pages_left;
  logic [CNT_W-1:0]  blocks_left;

  logic [SIZE_W:0]   size_ext;
  logic [SIZE_W:0]   page_sum;
  logic [SIZE_W:0]   blk_sum;
  logic [SIZE_W-1:0] blk_bytes;

  assign size_ext  = {1'b0, size};
  assign page_sum  = size_ext + (SIZE_W+1)'(PAGE_BYTES - 1);
  assign blk_sum   = size_ext + (SIZE_W+1)'(BLK_BYTES - 1);
  assign no_blocks = (blocks_left == '0);
  assign blk_pages = (pages_left >= CNT_W'(PAGES_PER_BLOCK)) ?
                     PIDX_W'(PAGES_PER_BLOCK) : PIDX_W'(pages_left);
  assign blk_bytes = (bytes_left >= SIZE_W'(BLK_BYTES)) ?
                     SIZE_W'(BLK_BYTES) : bytes_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_page    <= '0;
      blk_dst     <= '0;
      bytes_left  <= '0;
      pages_left  <= '0;
      blocks_left <= '0;
    end else if (load) begin
      blk_page    <= PAGE_W'(offset >> PS);
      blk_dst     <= base;
      bytes_left  <= size;
      pages_left  <= CNT_W'(page_sum >> PS);
      blocks_left <= CNT_W'(blk_sum >> BS);
    end else if (step) begin
      blk_page <= blk_page + PAGE_W'(PAGES_PER_BLOCK);
      if (keep) begin
        blk_dst     <= blk_dst + ADDR_W'(blk_bytes);
        bytes_left  <= bytes_left - blk_bytes;
        pages_left  <= pages_left - CNT_W'(blk_pages);
        blocks_left <= blocks_left - CNT_W'(1);
      end
    end
  end

  // R8: a dropped block leaves destination and owed counts untouched
  a_r8_skip_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !keep && !load) |=> ($stable(blk_dst) && $stable(bytes_left) &&
                                  $stable(pages_left) && $stable(blocks_left)));

  // R8: every finished block moves the page pointer by one block
  a_r8_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (blk_page == $past(blk_page) + PAGE_W'(PAGES_PER_BLOCK)));

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
  import nbl_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int SIZE_W          = 24,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int SECTORS         = 4,
  parameter int TIMEOUT_CYC     = 500000,
  localparam int PS     = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - PS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] img_offset,
  input  logic [SIZE_W-1:0] img_size,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PAGE_W-1:0] req_page,
  output logic [ADDR_W-1:0] req_dst,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic [7:0]        sec_status,
  input  logic [7:0]        sec_spare0,
  input  logic [7:0]        sec_spare1,
  output logic              rd_abandon,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        max_flips
);

  localparam int PIDX_W = $clog2(PAGES_PER_BLOCK) + 1;

  nbl_state_e        state;
  logic [PIDX_W-1:0] pg_idx;
  logic [2:0]        flips_max;
  logic              done_q, err_q, abandon_q;

  logic              load, arm, active, step, keep;
  logic              pg_fin, pg_ok, pg_mark, pg_timeout;
  logic [2:0]        pg_flips;
  logic              any_good, any_err, marked;
  logic              blk_bad, fatal, last_in_blk;
  logic [PAGE_W-1:0] blk_page;
  logic [ADDR_W-1:0] blk_dst;
  logic              no_blocks;
  logic [PIDX_W-1:0] blk_pages;

  assign load        = (state == ST_IDLE) && start;
  assign req_valid   = (state == ST_REQ);
  assign arm         = req_valid && req_ready;
  assign active      = (state == ST_COLLECT);
  assign blk_bad     = marked || !any_good;
  assign fatal       = !blk_bad && any_err;
  assign step        = (state == ST_VERDICT) && !fatal;
  assign keep        = !blk_bad;
  assign last_in_blk = ((pg_idx + PIDX_W'(1)) == blk_pages);
  assign req_page    = blk_page + PAGE_W'(pg_idx);
  assign req_dst     = blk_dst + (ADDR_W'(pg_idx) << PS);

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign error      = err_q;
  assign rd_abandon = abandon_q;
  assign max_flips  = flips_max;

  nbl_image_track #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .load(load),
    .offset(img_offset), .base(dst_base), .size(img_size),
    .step(step), .keep(keep),
    .blk_page(blk_page), .blk_dst(blk_dst),
    .no_blocks(no_blocks), .blk_pages(blk_pages)
  );

  nbl_sector_merge #(.SECTORS(SECTORS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_merge (
    .clk(clk), .rst_n(rst_n), .arm(arm), .active(active),
    .sec_valid(sec_valid), .sec_status(sec_status),
    .sec_spare0(sec_spare0), .sec_spare1(sec_spare1),
    .sec_ready(sec_ready), .pg_fin(pg_fin), .pg_ok(pg_ok),
    .pg_mark(pg_mark), .pg_flips(pg_flips), .pg_timeout(pg_timeout)
  );

  nbl_block_tally u_tally (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_BLOCK),
    .pg_fin(pg_fin), .pg_ok(pg_ok), .pg_mark(pg_mark),
    .any_good(any_good), .any_err(any_err), .marked(marked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pg_idx    <= '0;
      flips_max <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      abandon_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      abandon_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            flips_max <= '0;
            state     <= ST_BLOCK;
          end
        end
        ST_BLOCK: begin
          if (no_blocks) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            pg_idx <= '0;
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (pg_fin) begin
            abandon_q <= pg_timeout;
            if (pg_ok && (pg_flips > flips_max)) flips_max <= pg_flips;
            if ((pg_ok && pg_mark) || last_in_blk) begin
              state <= ST_VERDICT;
            end else begin
              pg_idx <= pg_idx + PIDX_W'(1);
              state  <= ST_REQ;
            end
          end
        end
        ST_VERDICT: begin
          if (fatal) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_BLOCK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a pending request is held steady
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_page) && $stable(req_dst)));

  // R11: request and sector channels are never open together
  a_r11_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ready |-> !req_valid);

  // R12: done is a lone pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: error is a lone pulse
  a_r12_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  // R12: outcomes are exclusive and coincide with idle
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!(done && error) && !busy));

  // R3: an empty image finishes two cycles after start
  a_r3_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && start && (img_size == '0)) |-> ##2 done);

  // R6: a marked readable page closes the block at once
  a_r6_marker_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pg_fin && pg_ok && pg_mark) |=> (state == ST_VERDICT));

  // R10: an abandoned page takes no more beats
  a_r10_abandon_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abandon |-> !sec_ready);

endmodule

// File: tb/nand_boot_loader_test.sv
module nand_boot_loader_test;

  localparam int AW  = 16;
  localparam int SW  = 12;
  localparam int PB  = 16;
  localparam int PPB = 4;
  localparam int NS  = 4;
  localparam int TMO = 20;
  localparam int PS  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] img_offset = '0;
  logic [SW-1:0] img_size = '0;
  logic [AW-1:0] dst_base = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-PS-1:0] req_page;
  logic [AW-1:0] req_dst;
  logic          sec_valid = 1'b0;
  logic          sec_ready;
  logic [7:0]    sec_status = '0;
  logic [7:0]    sec_spare0 = '0;
  logic [7:0]    sec_spare1 = '0;
  logic          rd_abandon, busy, done, error;
  logic [2:0]    max_flips;

  nand_boot_loader #(
    .ADDR_W(AW), .SIZE_W(SW), .PAGE_BYTES(PB),
    .PAGES_PER_BLOCK(PPB), .SECTORS(NS), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_offset(img_offset),
    .img_size(img_size), .dst_base(dst_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_page(req_page), .req_dst(req_dst),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_status(sec_status),
    .sec_spare0(sec_spare0), .sec_spare1(sec_spare1), .rd_abandon(rd_abandon),
    .busy(busy), .done(done), .error(error), .max_flips(max_flips)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // Flash fault table
  logic [7:0] st_mem [0:1023];
  logic [7:0] sp0_mem [0:255];
  logic [7:0] sp1_mem [0:255];
  logic       hang_mem [0:255];

  // Observed requests
  int log_n = 0;
  int log_page [0:511];
  int log_dst  [0:511];
  int beat_cnt = 0;
  int ab_cnt = 0;

  // Expected
  int exp_n;
  int exp_page [0:511];
  int exp_dst  [0:511];
  bit exp_err;
  int exp_flips;
  int exp_beats;
  int exp_ab;

  logic [31:0] rs = 32'h1234_5678;
  logic [31:0] rm = 32'h9e37_79b9;

  task automatic next_rs();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (sec_valid && sec_ready) beat_cnt++;
    if (rd_abandon) ab_cnt++;
  end

  // Page reader model
  initial begin : model
    int pg;
    int gaps;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      rm = rm ^ (rm << 13); rm = rm ^ (rm >> 17); rm = rm ^ (rm << 5);
      req_ready = rm[0] | rm[1];
      if (req_valid && req_ready) begin
        pg = int'(req_page) & 255;
        if (log_n < 512) begin
          log_page[log_n] = int'(req_page);
          log_dst[log_n]  = int'(req_dst);
        end
        log_n++;
        @(negedge clk);
        req_ready = 1'b0;
        if (hang_mem[pg]) begin
          while (!rd_abandon) @(negedge clk);
        end else begin
          for (int s = 0; s < NS; s++) begin
            rm = rm ^ (rm << 13); rm = rm ^ (rm >> 17); rm = rm ^ (rm << 5);
            gaps = int'(rm[1:0]) % 3;
            repeat (gaps) @(negedge clk);
            sec_valid  = 1'b1;
            sec_status = st_mem[pg*NS + s];
            sec_spare0 = (s == 0) ? sp0_mem[pg] : 8'h00;
            sec_spare1 = (s == 0) ? sp1_mem[pg] : 8'h00;
            while (!sec_ready) @(negedge clk);
            @(negedge clk);
            sec_valid = 1'b0;
          end
        end
      end
    end
  end

  function automatic bit readable(input int p);
    bit f;
    f = hang_mem[p & 255];
    for (int s = 0; s < NS; s++) f = f | st_mem[(p & 255)*NS + s][6];
    return !f;
  endfunction

  function automatic int page_flips(input int p);
    int m;
    int c;
    logic [7:0] st;
    m = 0;
    for (int s = 0; s < NS; s++) begin
      st = st_mem[(p & 255)*NS + s];
      c = st[3] ? (int'(st[5:4]) + 1) : 0;
      if (c > m) m = c;
    end
    return m;
  endfunction

  function automatic bit has_mark(input int p);
    return (sp0_mem[p & 255] != 8'hFF) || (sp1_mem[p & 255] != 8'hFF);
  endfunction

  task automatic build_table(input int mode, input int sp);
    int rel;
    for (int p = 0; p < 256; p++) begin
      rel = (p - sp) & 255;
      sp0_mem[p] = 8'hFF; sp1_mem[p] = 8'hFF; hang_mem[p] = 1'b0;
      for (int s = 0; s < NS; s++) begin
        next_rs();
        st_mem[p*NS + s] = rs[7:0] & 8'hBF;
      end
      next_rs();
      if ((mode == 1 || mode == 2 || mode == 3) && (rs[2:0] == 3'd0)) begin
        if (p[0]) sp0_mem[p] = 8'h00; else sp1_mem[p] = 8'h7E;
      end else if (((mode == 2 || mode == 3) && (rs[2:0] == 3'd1)) ||
                   (mode == 4 && (rel >> 2) == 1) || (mode == 5 && rel == 0)) begin
        st_mem[p*NS + int'(rs[9:8])] = st_mem[p*NS + int'(rs[9:8])] | 8'h40;
        sp0_mem[p] = 8'h00; sp1_mem[p] = 8'h00;
      end else if (mode == 3 && rs[5:2] == 4'd0) begin
        hang_mem[p] = 1'b1;
      end else if (mode == 5 && rel == 1) begin
        sp0_mem[p] = 8'h5A;
      end
    end
  endtask

  task automatic compute_expected(input int off, input int size, input int base);
    int page, bytes_left, pages_left, blocks_left, d, bp, good, badc, errc, i, p, guard, bb;
    page = off >> PS;
    bytes_left = size;
    pages_left = (size + PB - 1) / PB;
    blocks_left = (size + PB*PPB - 1) / (PB*PPB);
    d = base;
    exp_n = 0; exp_err = 0; exp_flips = 0; exp_beats = 0; exp_ab = 0;
    guard = 0;
    while (blocks_left > 0 && guard < 300) begin
      guard++;
      bp = (pages_left > PPB) ? PPB : pages_left;
      good = 0; badc = 0; errc = 0; i = 0;
      while (i < bp && badc == 0) begin
        p = (page + i) & ((1 << (AW-PS)) - 1);
        if (exp_n < 512) begin
          exp_page[exp_n] = p;
          exp_dst[exp_n] = (d + i*PB) & 16'hFFFF;
        end
        exp_n++;
        if (hang_mem[p & 255]) exp_ab++; else exp_beats += NS;
        if (readable(p)) begin
          good++;
          if (page_flips(p) > exp_flips) exp_flips = page_flips(p);
          if (has_mark(p)) badc++;
        end else errc++;
        i++;
      end
      if (good == 0) badc = errc;
      if (errc > 0 && badc == 0) begin
        exp_err = 1;
        break;
      end
      if (badc == 0) begin
        bb = (bytes_left > PB*PPB) ? PB*PPB : bytes_left;
        d = d + bb;
        bytes_left -= bb;
        pages_left -= bp;
        blocks_left--;
      end
      page += PPB;
    end
  endtask

  task automatic run_scenario(input int sc);
    int mode, off, size, base, cnt, mism, first_bad;
    bit got_done, got_err;
    int got_flips;
    string tag;
    mode = sc % 6;
    off  = (sc * 29) % 300;
    size = (sc == 0) ? 0 : ((sc * 37) % 230 + (sc % 3));
    base = 16'h4000 + sc * 7;
    build_table(mode, off >> PS);
    compute_expected(off, size, base);
    log_n = 0; beat_cnt = 0; ab_cnt = 0;

    @(negedge clk);
    img_offset = AW'(off); img_size = SW'(size); dst_base = AW'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; got_done = 0; got_err = 0; got_flips = 0;
    while (cnt < 5000) begin
      if (done || error) begin
        got_done = done; got_err = error; got_flips = int'(max_flips);
        break;
      end
      if (cnt == 2 && busy) begin
        // R2: start while busy must not disturb the running load
        img_offset = 16'h0100; img_size = 12'd5; dst_base = 16'h0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      cnt++;
    end
    check(got_done || got_err, "R12 outcome pulse seen", cnt, 0);
    @(negedge clk);
    check(!done && !error && !busy, "R12 pulse single and idle", int'({done, error, busy}), 0);

    if (size == 0) begin
      check(got_done && log_n == 0, "R3 empty image", log_n, 0);
    end

    tag = (mode == 4) ? "R7 unreadable block" : (mode == 5) ? "R6 marker forgives" : "R9 outcome error";
    check(got_err == exp_err, tag, int'(got_err), int'(exp_err));
    check(log_n == exp_n, "R4 request count", log_n, exp_n);

    mism = 0; first_bad = -1;
    for (int k = 0; k < exp_n && k < log_n && k < 512; k++) begin
      if (log_page[k] != exp_page[k] || log_dst[k] != exp_dst[k]) begin
        if (first_bad < 0) first_bad = k;
        mism++;
      end
    end
    if (first_bad >= 0)
      check(1'b0, "R2/R4/R8 request page", log_page[first_bad], exp_page[first_bad]);
    else
      check(1'b1, "R8 request sequence", mism, 0);

    check(beat_cnt == exp_beats, "R11 beats accepted", beat_cnt, exp_beats);
    check(ab_cnt == exp_ab, "R10 abandon pulses", ab_cnt, exp_ab);
    if (!exp_err && got_done)
      check(got_flips == exp_flips, "R5 max flips", got_flips, exp_flips);
  endtask

  bit finished = 0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !error && !rd_abandon && !req_valid, "R1 reset outputs",
          int'({busy, done, error, rd_abandon, req_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req_valid, "R1 idle after reset", int'({busy, req_valid}), 0);
    for (int sc = 0; sc < 48; sc++) run_scenario(sc);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule